// File: doc/BRIEF.md
# Fuse-gated write-once device-enable register

This block is an 8-bit configuration register that decides which on-chip functions are switched on. It is reached through a plain configuration port made of an address, a byte of write data, a write strobe and a byte of read data. The read data is combinational and is only non-zero when the address matches the register's offset, 9Ch. The block drives one enable line per device bit. It also reports the widest link the primary port is allowed to train to.

Bits 3:0 are write-once enables, and each one is qualified by its own feature-fuse input. With its fuse absent, a bit reads 0 and its enable line stays low, whatever was written and whatever the reset value says. With its fuse present, the first configuration write to the register loads the bit. That same write sets a lock flag that only reset clears, so a device that was switched off stays off until reset, and one that was switched on stays on. Bits 5:4 are ordinary read/write enables meant for run-time power management, and they stay writable after the lock is set. Bits 7:6 are reserved. Bit 3 turns on a secondary x4 port; when it is set, the primary port is limited to four lanes instead of eight.

Top module: `devgate_reg`

## Requirements
- R1: After reset with all four fuses present, a read at address 9Ch returns 33h: bits 5:4 are 1, bits 1:0 are 1, and bits 3:2 are 0. dev_en equals bits 5:0 of that value.
- R2: Read data bits 7:6 always read 0, and any value written to them is discarded.
- R3: Bits 5:4 reset to 1. Every write to 9Ch loads them from write data bits 5:4, before and after the lock. They appear on dev_en[5:4].
- R4: A bit n in 3:0 whose fuse_ok[n] is 0 reads 0 and drives dev_en[n] low after reset and after any write. A reset does not set it.
- R5: The first write to 9Ch after reset loads each bit n in 3:0 whose fuse is present from write data bit n, where 0 disables the device and 1 enables it.
- R6: After that first write, bits 3:0 keep their value through any later write until the next reset. A reset clears the lock and restores the reset value.
- R7: prim_max_lanes reads 8 while bit 3 reads 0 and reads 4 while bit 3 reads 1.
- R8: A read at any address other than 9Ch returns 0. A write to such an address changes no bit and does not set the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Configuration address |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_wdata | input | 8 | Write data byte |
| cfg_rdata | output | 8 | Read data, combinational, 0 when the address does not match |
| fuse_ok | input | 4 | Per-bit feature fuses for bits 3:0; 1 means the feature is present |
| dev_en | output | 6 | Effective enable per device bit 5:0 |
| prim_max_lanes | output | 4 | Maximum primary-port link width, 8 or 4 |

## Verification
The case that matters most is the first write. In that one cycle it loads the write-once bits, sets the lock, and updates the run-time bits. Every later write then combines a run-time update that must land with a write-once update that must be dropped. The bench sweeps all sixteen fuse patterns against all 256 values of the first write. Each trial is followed by a second write of the complemented byte, so every bit attempts a change in the cycle after the lock is taken. Each read-back is compared with a value built arithmetically from the fuse pattern and the two written bytes.

// File: rtl/devgate_pkg.sv
package devgate_pkg;
    localparam int REG_W    = 8;
    localparam int ADDR_W   = 8;
    localparam int NUM_WO   = 4;
    localparam int NUM_RW   = 2;
    localparam int RSV_W    = REG_W - NUM_WO - NUM_RW;
    localparam int RW_LSB   = NUM_WO;
    localparam int LINK_BIT = 3;
    localparam int LANE_W   = 4;

    typedef struct packed {
        logic              lock;
        logic [NUM_WO-1:0] bits;
    } wo_state_t;

    typedef struct packed {
        logic [NUM_RW-1:0] bits;
    } rw_state_t;
endpackage

// File: rtl/devgate_decode.sv
module devgate_decode #(
    parameter int                AW   = 8,
    parameter logic [AW-1:0]     ADDR = 8'h9C
) (
    input  logic [AW-1:0] cfg_addr,
    input  logic          cfg_wr,
    output logic          hit,
    output logic          wr_hit
);
    always_comb begin
        hit    = (cfg_addr == ADDR);
        wr_hit = hit && cfg_wr;
    end
endmodule

// File: rtl/devgate_wo_bank.sv
module devgate_wo_bank
    import devgate_pkg::*;
#(
    parameter logic [NUM_WO-1:0] RST = 4'b0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [NUM_WO-1:0] wdata,
    input  logic [NUM_WO-1:0] fuse,
    output logic [NUM_WO-1:0] eff,
    output logic              locked
);
    wo_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit && !st_q.lock) begin
            st_d.lock = 1'b1;
            for (int i = 0; i < NUM_WO; i++) begin
                if (fuse[i]) st_d.bits[i] = wdata[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lock <= 1'b0;
            st_q.bits <= RST;
        end else begin
            st_q <= st_d;
        end
    end

    // the fuse outranks both stored state and reset value
    for (genvar g = 0; g < NUM_WO; g++) begin : g_gate
        assign eff[g] = st_q.bits[g] & fuse[g];
    end

    assign locked = st_q.lock;

    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock);

    a_r6_bits_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> $stable(st_q.bits));

    a_r5_first_write_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !st_q.lock) |=> st_q.lock);

    a_r5_first_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !st_q.lock) |=> (((st_q.bits ^ $past(wdata)) & $past(fuse)) == '0));
endmodule

// File: rtl/devgate_rw_bank.sv
module devgate_rw_bank
    import devgate_pkg::*;
#(
    parameter logic [NUM_RW-1:0] RST = 2'b11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [NUM_RW-1:0] wdata,
    output logic [NUM_RW-1:0] bits
);
    rw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) st_d.bits = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bits <= RST;
        else        st_q <= st_d;
    end

    assign bits = st_q.bits;

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (st_q.bits == $past(wdata)));

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(st_q.bits));
endmodule

// File: rtl/devgate_reg.sv
module devgate_reg
    import devgate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_ADDR     = 8'h9C,
    parameter logic [NUM_WO-1:0] WO_RST       = 4'b0011,
    parameter logic [NUM_RW-1:0] RW_RST       = 2'b11,
    parameter logic [LANE_W-1:0] WIDE_LANES   = 4'd8,
    parameter logic [LANE_W-1:0] NARROW_LANES = 4'd4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic                      cfg_wr,
    input  logic [REG_W-1:0]          cfg_wdata,
    output logic [REG_W-1:0]          cfg_rdata,
    input  logic [NUM_WO-1:0]         fuse_ok,
    output logic [NUM_WO+NUM_RW-1:0]  dev_en,
    output logic [LANE_W-1:0]         prim_max_lanes
);
    logic              hit, wr_hit, locked;
    logic [NUM_WO-1:0] wo_eff;
    logic [NUM_RW-1:0] rw_bits;
    logic              unused_rsv;

    devgate_decode #(.AW(ADDR_W), .ADDR(REG_ADDR)) u_decode (
        .cfg_addr (cfg_addr),
        .cfg_wr   (cfg_wr),
        .hit      (hit),
        .wr_hit   (wr_hit)
    );

    devgate_wo_bank #(.RST(WO_RST)) u_wo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (cfg_wdata[NUM_WO-1:0]),
        .fuse   (fuse_ok),
        .eff    (wo_eff),
        .locked (locked)
    );

    devgate_rw_bank #(.RST(RW_RST)) u_rw (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (cfg_wdata[RW_LSB +: NUM_RW]),
        .bits   (rw_bits)
    );

    // reserved write bits are dropped on purpose
    assign unused_rsv = &{1'b0, cfg_wdata[REG_W-1 -: RSV_W], locked};

    always_comb begin
        dev_en         = {rw_bits, wo_eff};
        cfg_rdata      = hit ? {{RSV_W{1'b0}}, rw_bits, wo_eff} : '0;
        prim_max_lanes = wo_eff[LINK_BIT] ? NARROW_LANES : WIDE_LANES;
    end

    a_r4_dark_stays_dark: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(fuse_ok) && !fuse_ok[LINK_BIT] |=> (prim_max_lanes == WIDE_LANES));

    a_r8_foreign_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !hit && $stable(fuse_ok)) |=> $stable(dev_en));
endmodule

// File: tb/devgate_reg_tb.sv
module devgate_reg_tb;
    localparam int PERIOD = 10;
    localparam logic [7:0] RA = 8'h9C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_addr = RA;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [3:0] fuse_ok = 4'hF;
    logic [5:0] dev_en;
    logic [3:0] prim_max_lanes;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    devgate_reg u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fuse_ok(fuse_ok),
        .dev_en(dev_en), .prim_max_lanes(prim_max_lanes)
    );

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h fuse=%h", req, act, exp, fuse_ok);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_wr = 1'b0;
        cfg_addr = RA;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        cfg_wdata = d;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_addr = RA;
        #1;
    endtask

    function automatic logic [7:0] img(logic [1:0] rw, logic [3:0] wo);
        return {2'b00, rw, wo};
    endfunction

    function automatic logic [7:0] lanes(logic [3:0] wo);
        return wo[3] ? 8'd4 : 8'd8;
    endfunction

    initial begin
        // fixed scenarios with all fuses present
        fuse_ok = 4'hF;
        do_reset();
        #1;
        check8("R1 reset image", cfg_rdata, 8'h33);
        check8("R1 reset dev_en", {2'b00, dev_en}, 8'h33);
        check8("R7 reset lanes", {4'h0, prim_max_lanes}, 8'd8);
        cfg_addr = 8'h9D;
        #1;
        check8("R8 foreign read", cfg_rdata, 8'h00);
        do_write(8'h9D, 8'h0C);
        check8("R8 foreign write ignored", cfg_rdata, 8'h33);
        do_write(RA, 8'hCC);
        check8("R8 foreign write did not lock", cfg_rdata, 8'h0C);
        check8("R2 reserved dropped", {cfg_rdata[7:6], 6'h00}, 8'h00);
        check8("R7 narrow lanes", {4'h0, prim_max_lanes}, 8'd4);
        do_reset();
        #1;
        check8("R6 reset clears lock", cfg_rdata, 8'h33);
        do_write(RA, 8'hFF);
        check8("R2 reserved write", cfg_rdata, 8'h3F);

        // sweep: every fuse pattern against every first-write byte
        for (int f = 0; f < 16; f++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] v1, v2;
                logic [3:0] wo;
                v1 = v[7:0];
                v2 = ~v1;
                fuse_ok = f[3:0];
                do_reset();
                #1;
                check8("R4 reset under fuse", cfg_rdata, img(2'b11, 4'b0011 & f[3:0]));
                do_write(RA, v1);
                wo = v1[3:0] & f[3:0];
                check8("R5 first write", cfg_rdata, img(v1[5:4], wo));
                check8("R4 dev_en gated", {2'b00, dev_en}, img(v1[5:4], wo));
                check8("R7 lanes after load", {4'h0, prim_max_lanes}, lanes(wo));
                do_write(RA, v2);
                check8("R6 second write locked, R3 rw toggles", cfg_rdata, img(v2[5:4], wo));
                do_write(RA, v1);
                check8("R3 rw after lock", {2'b00, dev_en}, img(v1[5:4], wo));
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule